// File: doc/BRIEF.md
# Two-Level Page Access Permission Checker

This block decides whether a single memory access is allowed by a two-level translation path. It looks at a directory entry and, when that entry does not map a large page, at the leaf entry beneath it. It then produces three results: a fault flag, a 6-bit fault error code, and the updated accessed and dirty bits for both entries. The checks cover entry validity (present, reserved bits, no-execute used while disabled), the combined access rights, the supervisor write-protect override, supervisor-fetch protection from user pages, and protection keys.

Fetching the entries is done elsewhere. The caller presents the flag bits of both entries, the access type and the control bits, then pulses `req`. One clock later `valid` is high for one cycle, and the registered results stay on the outputs until the next request.

Top module: `pg_perm_check`

## Requirements
- R1: `valid` goes high exactly one cycle after `req` is sampled and is low otherwise. The result outputs change only in the cycle after a request and otherwise hold their values. Reset clears `valid`, `fault`, `err_code` and all four updated A/D outputs.
- R2: The error code has this layout: bit0 = present, bit1 = write, bit2 = user, bit3 = reserved, bit4 = fetch, bit5 = protection key. Bit0 is 1 unless a non-present entry is found. Bits 1, 2 and 4 copy `acc_write`, `acc_user` and `acc_fetch` whether or not the access faults (bit4 is subject to R12).
- R3: The directory is invalid in any of these cases: it is not present; `dir_rsv51` is set; `dir_nx` is set while `nx_en` is clear; or `dir_large` and `dir_rsv13` are both set. An invalid directory faults. If it is present, the fault sets bit3; if it is not present, the fault clears bit0. The leaf inputs then have no effect on any output.
- R4: When the directory is valid and not large, the leaf is checked the same way using `leaf_present`, `leaf_rsv51` and `leaf_nx`. An invalid leaf faults, with bit3 and bit0 set as in R3.
- R5: The effective writable, user and executable rights are the AND of the directory and leaf rights. When `dir_large` is set, only the directory rights apply.
- R6: A user access to a page without the user right faults. A write without the writable right faults unless R7 allows it. A fetch from a page without the executable right faults.
- R7: A supervisor write (`acc_user`=0) to a read-only page is allowed when `wp` is clear.
- R8: When `smep` is set, a fetch from a page that has the user right faults.
- R9: Key checks apply to a non-fetch access to a user page when both `key_sel` and `key_en` are set. In that case `key_ad` causes a fault. Otherwise `key_wd` causes a fault on a write that R7 does not allow. Either key fault sets bit5.
- R10: When there is no fault, the final entry (the leaf, or the directory when it is large) gets its accessed output set. On a write it also gets its dirty output set. A/D bits that are already set stay set.
- R11: Whenever the leaf is walked, the directory accessed output is set, even if the leaf faults.
- R12: When `nx_en` and `smep` are both clear, error bit4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Evaluate the presented inputs this cycle |
| dir_present | input | 1 | Directory present bit |
| dir_write | input | 1 | Directory writable right |
| dir_user | input | 1 | Directory user right |
| dir_acc | input | 1 | Directory accessed bit as stored |
| dir_dirty | input | 1 | Directory dirty bit as stored |
| dir_nx | input | 1 | Directory no-execute bit |
| dir_rsv51 | input | 1 | Directory high reserved bit |
| dir_rsv13 | input | 1 | Directory large-page reserved bit |
| dir_large | input | 1 | Directory maps a large page |
| leaf_present | input | 1 | Leaf present bit |
| leaf_write | input | 1 | Leaf writable right |
| leaf_user | input | 1 | Leaf user right |
| leaf_acc | input | 1 | Leaf accessed bit as stored |
| leaf_dirty | input | 1 | Leaf dirty bit as stored |
| leaf_nx | input | 1 | Leaf no-execute bit |
| leaf_rsv51 | input | 1 | Leaf high reserved bit |
| key_sel | input | 1 | Final entry selects the checked key |
| acc_user | input | 1 | Access made in user mode |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| nx_en | input | 1 | No-execute enable |
| wp | input | 1 | Supervisor write-protect enable |
| smep | input | 1 | Supervisor fetch-from-user protection enable |
| key_en | input | 1 | Protection keys enable |
| key_ad | input | 1 | Selected key access-disable |
| key_wd | input | 1 | Selected key write-disable |
| valid | output | 1 | Result valid, one cycle after `req` |
| fault | output | 1 | Access faults |
| err_code | output | 6 | Fault error code (layout in R2) |
| new_dir_acc | output | 1 | Directory accessed bit after the access |
| new_dir_dirty | output | 1 | Directory dirty bit after the access |
| new_leaf_acc | output | 1 | Leaf accessed bit after the access |
| new_leaf_dirty | output | 1 | Leaf dirty bit after the access |

## Verification
The hardest case to reach is a key fault. It needs a valid path, a page with the user right, a non-fetch access, and both `key_sel` and `key_en` set, all at once. For the write-disable variant it also needs a write that the write-protect override does not cover. Uniform random input vectors hit this only rarely. The stimulus therefore has a second random phase that forces a valid, user-accessible path with keys on, and directed vectors that cover both the access-disable and the write-disable branches. Invalid-directory vectors are paired with random leaf bits, which shows that the leaf has no effect once the directory fails.

// File: rtl/pg_perm_check.sv
module pg_perm_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       dir_present,
  input  logic       dir_write,
  input  logic       dir_user,
  input  logic       dir_acc,
  input  logic       dir_dirty,
  input  logic       dir_nx,
  input  logic       dir_rsv51,
  input  logic       dir_rsv13,
  input  logic       dir_large,
  input  logic       leaf_present,
  input  logic       leaf_write,
  input  logic       leaf_user,
  input  logic       leaf_acc,
  input  logic       leaf_dirty,
  input  logic       leaf_nx,
  input  logic       leaf_rsv51,
  input  logic       key_sel,
  input  logic       acc_user,
  input  logic       acc_write,
  input  logic       acc_fetch,
  input  logic       nx_en,
  input  logic       wp,
  input  logic       smep,
  input  logic       key_en,
  input  logic       key_ad,
  input  logic       key_wd,
  output logic       valid,
  output logic       fault,
  output logic [5:0] err_code,
  output logic       new_dir_acc,
  output logic       new_dir_dirty,
  output logic       new_leaf_acc,
  output logic       new_leaf_dirty
);

  logic dir_ok, walk_leaf, leaf_ok, path_ok;
  logic eff_w, eff_u, eff_x, kern_w;
  logic key_hit, key_f, perm_f, grant;
  logic miss_present;
  logic [5:0] err_c;

  assign dir_ok    = dir_present & ~dir_rsv51 & ~(dir_large & dir_rsv13) & ~(dir_nx & ~nx_en);
  assign walk_leaf = dir_ok & ~dir_large;
  assign leaf_ok   = leaf_present & ~leaf_rsv51 & ~(leaf_nx & ~nx_en);
  assign path_ok   = dir_ok & (dir_large | leaf_ok);

  assign eff_w  = dir_write & (dir_large | leaf_write);
  assign eff_u  = dir_user  & (dir_large | leaf_user);
  assign eff_x  = ~dir_nx   & (dir_large | ~leaf_nx);
  assign kern_w = ~wp & ~acc_user;

  assign key_hit = eff_u & ~acc_fetch & key_sel & key_en;
  assign key_f   = key_hit & (key_ad | (acc_write & key_wd & ~kern_w));
  assign perm_f  = (acc_user  & ~eff_u)
                 | (acc_write & ~eff_w & ~kern_w)
                 | (acc_fetch & ~eff_x)
                 | (acc_fetch & eff_u & smep)
                 | key_f;
  assign grant   = path_ok & ~perm_f;

  assign miss_present = dir_ok ? (~dir_large & ~leaf_present) : ~dir_present;

  assign err_c = {path_ok & key_f,
                  acc_fetch & (nx_en | smep),
                  ~path_ok & ~miss_present,
                  acc_user,
                  acc_write,
                  ~miss_present};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid          <= 1'b0;
      fault          <= 1'b0;
      err_code       <= '0;
      new_dir_acc    <= 1'b0;
      new_dir_dirty  <= 1'b0;
      new_leaf_acc   <= 1'b0;
      new_leaf_dirty <= 1'b0;
    end else begin
      valid <= req;
      if (req) begin
        fault          <= ~grant;
        err_code       <= err_c;
        new_dir_acc    <= dir_acc | walk_leaf | (dir_large & grant);
        new_dir_dirty  <= dir_dirty | (dir_large & grant & acc_write);
        new_leaf_acc   <= leaf_acc | (walk_leaf & grant);
        new_leaf_dirty <= leaf_dirty | (walk_leaf & grant & acc_write);
      end
    end
  end

endmodule

// File: rtl/pg_perm_check_props.sv
module pg_perm_check_props (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       dir_acc,
  input logic       leaf_dirty,
  input logic       acc_fetch,
  input logic       nx_en,
  input logic       smep,
  input logic       valid,
  input logic       fault,
  input logic [5:0] err_code,
  input logic       new_dir_acc,
  input logic       new_leaf_dirty
);

  assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid);

  assert_no_valid_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !valid);

  assert_hold_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(err_code) && $stable(fault));

  assert_grant_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !fault |-> err_code[0] && !err_code[3] && !err_code[5]);

  assert_absent_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !err_code[0] |-> fault && !err_code[3]);

  assert_fetch_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(!nx_en && !smep) |-> !err_code[4]);

  assert_fetch_bit_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !$past(acc_fetch) |-> !err_code[4]);

  assert_sticky_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(dir_acc) |-> new_dir_acc);

  assert_sticky_dirty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(leaf_dirty) |-> new_leaf_dirty);

endmodule

bind pg_perm_check pg_perm_check_props u_props (
  .clk           (clk),
  .rst_n         (rst_n),
  .req           (req),
  .dir_acc       (dir_acc),
  .leaf_dirty    (leaf_dirty),
  .acc_fetch     (acc_fetch),
  .nx_en         (nx_en),
  .smep          (smep),
  .valid         (valid),
  .fault         (fault),
  .err_code      (err_code),
  .new_dir_acc   (new_dir_acc),
  .new_leaf_dirty(new_leaf_dirty)
);

// File: tb/tb_pg_perm_check.sv
module tb_pg_perm_check;
  localparam int CLK_PERIOD = 10;

  // stimulus vector bit positions (bench-local)
  localparam int DP=0, DW=1, DU=2, DA=3, DD=4, DNX=5, D51=6, D13=7, DLG=8;
  localparam int LP=9, LW=10, LU=11, LA=12, LD=13, LNX=14, L51=15;
  localparam int KSEL=16, AU=17, AW=18, AF=19, NXE=20, WPB=21, SME=22, KEN=23, KAD=24, KWD=25;

  logic clk = 0, rst_n = 0, req = 0;
  logic [25:0] s = '0;
  logic valid, fault, new_dir_acc, new_dir_dirty, new_leaf_acc, new_leaf_dirty;
  logic [5:0] err_code;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_perm_check dut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .dir_present(s[DP]), .dir_write(s[DW]), .dir_user(s[DU]), .dir_acc(s[DA]),
    .dir_dirty(s[DD]), .dir_nx(s[DNX]), .dir_rsv51(s[D51]), .dir_rsv13(s[D13]),
    .dir_large(s[DLG]), .leaf_present(s[LP]), .leaf_write(s[LW]), .leaf_user(s[LU]),
    .leaf_acc(s[LA]), .leaf_dirty(s[LD]), .leaf_nx(s[LNX]), .leaf_rsv51(s[L51]),
    .key_sel(s[KSEL]), .acc_user(s[AU]), .acc_write(s[AW]), .acc_fetch(s[AF]),
    .nx_en(s[NXE]), .wp(s[WPB]), .smep(s[SME]), .key_en(s[KEN]), .key_ad(s[KAD]),
    .key_wd(s[KWD]), .valid(valid), .fault(fault), .err_code(err_code),
    .new_dir_acc(new_dir_acc), .new_dir_dirty(new_dir_dirty),
    .new_leaf_acc(new_leaf_acc), .new_leaf_dirty(new_leaf_dirty));

  // expected {fault, err[5:0], dir_acc, dir_dirty, leaf_acc, leaf_dirty}
  function automatic logic [10:0] model(input logic [25:0] v);
    logic f, w, u, x, kw, ok;
    logic [5:0] e;
    logic da, dd, la, ld, leaf_used;
    f = 0; e = 6'b000001;
    e[1] = v[AW]; e[2] = v[AU]; e[4] = v[AF];
    da = v[DA]; dd = v[DD]; la = v[LA]; ld = v[LD];
    leaf_used = 0; ok = 1;
    if (!v[DP] || v[D51] || (v[DLG] && v[D13]) || (v[DNX] && !v[NXE])) begin
      f = 1; ok = 0;
      if (v[DP]) e[3] = 1; else e[0] = 0;
    end else begin
      w = v[DW]; u = v[DU]; x = !v[DNX];
      if (!v[DLG]) begin
        leaf_used = 1; da = 1;
        if (!v[LP] || v[L51] || (v[LNX] && !v[NXE])) begin
          f = 1; ok = 0;
          if (v[LP]) e[3] = 1; else e[0] = 0;
        end else begin
          w = w && v[LW]; u = u && v[LU]; x = x && !v[LNX];
        end
      end
      if (ok) begin
        kw = !v[WPB] && !v[AU];
        if (v[AU] && !u) f = 1;
        if (v[AW] && !w && !kw) f = 1;
        if (v[AF] && !x) f = 1;
        if (v[AF] && u && v[SME]) f = 1;
        if (u && !v[AF] && v[KSEL] && v[KEN]) begin
          if (v[KAD]) begin f = 1; e[5] = 1; end
          else if (v[AW] && v[KWD] && !kw) begin f = 1; e[5] = 1; end
        end
        if (!f) begin
          if (leaf_used) begin la = 1; ld = ld | v[AW]; end
          else begin da = 1; dd = dd | v[AW]; end
        end
      end
    end
    if (!v[NXE] && !v[SME]) e[4] = 0;
    return {f, e, da, dd, la, ld};
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input logic [25:0] v, input string tag);
    @(negedge clk);
    s = v; req = 1;
    @(negedge clk);
    req = 0;
    checks++;
    if (valid !== 1'b1) begin
      fails++;
      $display("FAIL R1 valid after req (%s): actual %b expected 1", tag, valid);
    end
    check(tag, {fault, err_code, new_dir_acc, new_dir_dirty, new_leaf_acc, new_leaf_dirty}, model(v));
  endtask

  function automatic logic [25:0] good_path();
    logic [25:0] v = '0;
    v[DP]=1; v[DW]=1; v[DU]=1; v[LP]=1; v[LW]=1; v[LU]=1; v[NXE]=1; v[WPB]=1;
    return v;
  endfunction

  logic [10:0] held;
  logic [25:0] v;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset", {valid, fault, err_code, new_dir_acc, new_dir_dirty, new_leaf_acc, new_leaf_dirty}, 11'b0);
    rst_n = 1;

    v = good_path(); v[AU] = 1; run(v, "R2 user read ok");
    check("R2 err layout", {5'b0, err_code}, 11'b000_0000_0101);
    v = '0; run(v, "R3 dir absent");
    v = good_path(); v[D51] = 1; v[LP] = 0; run(v, "R3 dir rsv51 leaf ignored");
    check("R3 reserved bit", {10'b0, err_code[3]}, 11'd1);
    v = good_path(); v[DLG]=1; v[D13]=1; run(v, "R3 large rsv13");
    v = good_path(); v[D13]=1; run(v, "R3 rsv13 ignored without large");
    v = good_path(); v[DNX]=1; v[NXE]=0; run(v, "R3 dir nx while disabled");
    v = good_path(); v[LP]=0; run(v, "R4 leaf absent");
    v = good_path(); v[L51]=1; v[AW]=1; run(v, "R4 leaf rsv51");
    v = good_path(); v[LW]=0; v[AW]=1; v[AU]=1; run(v, "R5 leaf read-only");
    v = good_path(); v[DLG]=1; v[LW]=0; v[LU]=0; v[AW]=1; v[AU]=1; run(v, "R5 large ignores leaf");
    v = good_path(); v[DU]=0; v[AU]=1; run(v, "R6 user to supervisor page");
    v = good_path(); v[LNX]=1; v[AF]=1; v[LU]=0; run(v, "R6 fetch no-exec");
    v = good_path(); v[LW]=0; v[AW]=1; v[WPB]=0; run(v, "R7 wp clear override");
    v = good_path(); v[LW]=0; v[AW]=1; v[WPB]=1; run(v, "R7 wp set faults");
    v = good_path(); v[AF]=1; v[SME]=1; run(v, "R8 smep user fetch");
    v = good_path(); v[KSEL]=1; v[KEN]=1; v[KAD]=1; run(v, "R9 key access-disable");
    v = good_path(); v[KSEL]=1; v[KEN]=1; v[KWD]=1; v[AW]=1; run(v, "R9 key write-disable");
    v = good_path(); v[KSEL]=1; v[KEN]=1; v[KWD]=1; v[AW]=1; v[WPB]=0; run(v, "R9 key wd with override");
    v = good_path(); v[KSEL]=1; v[KEN]=0; v[KAD]=1; run(v, "R9 keys disabled");
    v = good_path(); v[AW]=1; run(v, "R10 write sets dirty");
    v = good_path(); v[DLG]=1; v[AW]=1; run(v, "R10 large write");
    v = good_path(); v[LU]=0; v[AU]=1; run(v, "R11 dir acc on leaf fault");
    v = good_path(); v[AF]=1; v[NXE]=0; v[LU]=0; run(v, "R12 fetch bit suppressed");

    // R1 hold: change inputs without req
    held = {fault, err_code, new_dir_acc, new_dir_dirty, new_leaf_acc, new_leaf_dirty};
    @(negedge clk); s = ~s;
    @(negedge clk);
    check("R1 hold without req", {valid, fault, err_code, new_dir_acc, new_dir_dirty, new_leaf_acc, new_leaf_dirty}, {1'b0, held});

    for (int i = 0; i < 3000; i++) begin
      v = $urandom();
      run(v, "R5 random");
    end
    for (int i = 0; i < 1500; i++) begin
      v = $urandom() | good_path();
      v[D51]=0; v[L51]=0; v[D13]=0; v[KEN]=1; v[KSEL]=1; v[AF]=0;
      run(v, "R9 random keys");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule